// File: doc/BRIEF.md
# Baseband DC Notch with Interference Hold

This block strips leftover DC from a signed complex baseband stream. Coarse correction has already been applied upstream. The I and Q rails each keep a leaky-integrator estimate of their mean and subtract it from every valid sample, so the path has a narrow notch at zero frequency. A right-shift setting picks the loop gain and therefore the notch width. The nominal setting is 15, a gain of 2^-15.

A companion detector squares and sums the two current estimates. It compares that power with a programmable threshold, using squared full-scale units where full scale squared is 2^(2*(DW-1)). When the measured power sits above the threshold, the estimates stop updating and hold their values. When it falls back, tracking resumes. The hold state is shown on a status pin. The nominal threshold for a 16-bit path is 853, which corresponds to about -61 dBFS. Correction with the held estimate continues while updates are stopped.

Top module: `dcn_notch`

## Requirements
- R1: After reset, out_valid, out_i, out_q and frozen are all 0, and both estimates are zero, so the first valid sample leaves the block unchanged.
- R2: out_valid equals in_valid delayed by one clock. On a valid sample, out_i/out_q become in_i/in_q minus the estimate held before that sample. When there is no valid sample, out_i and out_q keep their values.
- R3: Each estimate is an accumulator with FRAC=16 fractional bits. On a valid sample while not frozen it becomes acc + ((x*2^16 - acc) >>> k). The estimate is floor(acc / 2^16). Cycles without in_valid leave it unchanged.
- R4: The shift k is shift_k clamped to the range 8 to 20. Values below 8 act as 8, and values above 20 act as 20.
- R5: The difference is saturated to the signed DW-bit range, from -2^(DW-1) to 2^(DW-1)-1.
- R6: On each valid sample the measured power is est_i^2 + est_q^2, taken from the estimates before the update. The sample counts as "above" when the power is strictly greater than thresh (unsigned, 2*DW bits).
- R7: frozen rises after two consecutive valid samples that are above while unfrozen. It changes at the clock edge of the second of those samples.
- R8: frozen falls after two consecutive valid samples that are not above while frozen.
- R9: While frozen, valid samples do not change the estimates, and the output is still corrected with the held estimates.
- R10: A single valid sample on the opposite side, followed by a valid sample on the current side, leaves frozen unchanged and restarts the two-sample count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample qualifier |
| in_i | input | DW | Signed I sample |
| in_q | input | DW | Signed Q sample |
| shift_k | input | 5 | Loop gain shift, clamped to 8..20 |
| thresh | input | 2*DW | Hold threshold in squared full-scale units |
| out_valid | output | 1 | Output sample qualifier |
| out_i | output | DW | Corrected signed I |
| out_q | output | DW | Corrected signed Q |
| frozen | output | 1 | Estimate updates are held |

## Verification
The assertions assume that in_valid is low for the whole of reset. They also assume that shift_k is driven to a known value once reset ends, because the clamp check and the freeze-edge checks trace back to the sample that caused them. The stimulus keeps in_valid low during reset. It changes shift_k and thresh only on the falling clock edge, between samples, so every sample sees one stable setting. Data covers the full signed range, including both rails at their extremes, to reach saturation.

// File: rtl/dcn_pkg.sv
package dcn_pkg;
  localparam int unsigned SHIFT_LO   = 8;
  localparam int unsigned SHIFT_HI   = 20;
  localparam int unsigned SHIFT_DFLT = 15;
  // about -61 dBFS for a 16-bit path: 10^-6.1 * 2^30
  localparam int unsigned THRESH_DFLT = 853;

  typedef enum logic {ST_TRACK = 1'b0, ST_HOLD = 1'b1} hold_state_t;

  function automatic logic [4:0] clamp_shift(input logic [4:0] k);
    if (k < 5'(SHIFT_LO))      return 5'(SHIFT_LO);
    else if (k > 5'(SHIFT_HI)) return 5'(SHIFT_HI);
    else                       return k;
  endfunction
endpackage

// File: rtl/dcn_track.sv
module dcn_track #(
  parameter int DW   = 16,
  parameter int FRAC = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  logic                 hold,
  input  logic [4:0]           k,
  input  logic signed [DW-1:0] x,
  output logic signed [DW-1:0] est
);
  localparam int AW = DW + FRAC + 1;

  logic signed [AW-1:0] acc, acc_nx;
  logic signed [AW:0]   x_ext, diff, step;
  logic                 upd_evt;

  assign upd_evt = smp_vld && !hold;
  assign x_ext   = {{(AW+1-DW-FRAC){x[DW-1]}}, x, {FRAC{1'b0}}};
  assign diff    = x_ext - {acc[AW-1], acc};
  assign step    = diff >>> k;
  assign acc_nx  = acc + step[AW-1:0];
  assign est     = acc[FRAC +: DW];

  always_ff @(posedge clk) begin
    if (!rst_n)       acc <= '0;
    else if (upd_evt) acc <= acc_nx;
  end

  // R3 R9
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld || hold) |=> $stable(acc));
endmodule

// File: rtl/dcn_detect.sv
module dcn_detect #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  logic signed [DW-1:0] est_i,
  input  logic signed [DW-1:0] est_q,
  input  logic [2*DW-1:0]      thresh,
  output logic                 frozen
);
  import dcn_pkg::*;

  logic signed [2*DW-1:0] sq_i, sq_q;
  logic [2*DW-1:0]        pwr;
  logic                   above, opposite, pend;
  hold_state_t            st;

  assign sq_i     = est_i * est_i;
  assign sq_q     = est_q * est_q;
  assign pwr      = $unsigned(sq_i) + $unsigned(sq_q);
  assign above    = pwr > thresh;
  assign opposite = above != (st == ST_HOLD);
  assign frozen   = (st == ST_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_TRACK;
      pend <= 1'b0;
    end else if (smp_vld) begin
      if (opposite && pend) begin
        st   <= above ? ST_HOLD : ST_TRACK;
        pend <= 1'b0;
      end else begin
        pend <= opposite;
      end
    end
  end

  // R7
  freeze_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frozen) |-> $past(smp_vld && above && pend));
  // R8
  freeze_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frozen) |-> $past(smp_vld && !above && pend));
  // R10
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !opposite) |=> !pend);
endmodule

// File: rtl/dcn_notch.sv
module dcn_notch #(
  parameter int DW   = 16,
  parameter int FRAC = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic [4:0]           shift_k,
  input  logic [2*DW-1:0]      thresh,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q,
  output logic                 frozen
);
  import dcn_pkg::*;

  localparam int NCH = 2;

  logic [4:0]           k_eff;
  logic signed [DW-1:0] x_ch   [NCH];
  logic signed [DW-1:0] est_ch [NCH];
  logic signed [DW-1:0] y_ch   [NCH];
  logic                 hold_w;

  function automatic logic signed [DW-1:0] sat_sub(input logic signed [DW-1:0] a,
                                                  input logic signed [DW-1:0] b);
    logic signed [DW:0] d;
    d = {a[DW-1], a} - {b[DW-1], b};
    if (d[DW] != d[DW-1]) return d[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    return d[DW-1:0];
  endfunction

  assign k_eff   = clamp_shift(shift_k);
  assign x_ch[0] = in_i;
  assign x_ch[1] = in_q;
  assign out_i   = y_ch[0];
  assign out_q   = y_ch[1];
  assign frozen  = hold_w;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dcn_track #(.DW(DW), .FRAC(FRAC)) u_trk (
      .clk    (clk),
      .rst_n  (rst_n),
      .smp_vld(in_valid),
      .hold   (hold_w),
      .k      (k_eff),
      .x      (x_ch[c]),
      .est    (est_ch[c])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)        y_ch[c] <= '0;
      else if (in_valid) y_ch[c] <= sat_sub(x_ch[c], est_ch[c]);
    end
  end

  dcn_detect #(.DW(DW)) u_det (
    .clk    (clk),
    .rst_n  (rst_n),
    .smp_vld(in_valid),
    .est_i  (est_ch[0]),
    .est_q  (est_ch[1]),
    .thresh (thresh),
    .frozen (hold_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  // R4
  always_comb begin
    if (rst_n) begin
      shift_range_chk: assert (k_eff >= 5'(SHIFT_LO) && k_eff <= 5'(SHIFT_HI));
    end
  end

  // R2
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_i) && $stable(out_q)));
endmodule

// File: tb/tb_dcn_notch.sv
`timescale 1ns/1ps
module tb_dcn_notch;
  localparam int DW = 16;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic signed [DW-1:0] in_i = '0, in_q = '0;
  logic [4:0]           shift_k = 5'd15;
  logic [2*DW-1:0]      thresh = 32'd853;
  logic                 out_valid, frozen;
  logic signed [DW-1:0] out_i, out_q;

  int total = 0, bad = 0;
  string req = "R1";

  // reference state
  longint acc_m[2];
  bit     frz_m, pend_m, ov_m;
  longint oi_m, oq_m;

  always #4 clk = ~clk;

  dcn_notch #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .shift_k(shift_k), .thresh(thresh), .out_valid(out_valid),
    .out_i(out_i), .out_q(out_q), .frozen(frozen)
  );

  function automatic longint satv(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic check(string r, longint act, longint exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic model(bit v, longint xi, longint xq);
    int k;
    longint ei, eq, p;
    bit ab;
    ov_m = v;
    if (!v) return;
    k = (shift_k < 8) ? 8 : (shift_k > 20) ? 20 : int'(shift_k);
    ei = acc_m[0] >>> 16;
    eq = acc_m[1] >>> 16;
    oi_m = satv(xi - ei);
    oq_m = satv(xq - eq);
    p  = ei*ei + eq*eq;
    ab = p > longint'(thresh);
    if (!frz_m) begin
      acc_m[0] = acc_m[0] + ((xi*65536 - acc_m[0]) >>> k);
      acc_m[1] = acc_m[1] + ((xq*65536 - acc_m[1]) >>> k);
    end
    if (ab != frz_m) begin
      if (pend_m) begin frz_m = ab; pend_m = 0; end
      else pend_m = 1;
    end else pend_m = 0;
  endtask

  // drive at a falling edge, compare at the next falling edge
  task automatic step(bit v, longint xi, longint xq);
    in_valid = v;
    in_i = DW'(xi);
    in_q = DW'(xq);
    model(v, xi, xq);
    @(negedge clk);
    check(req, out_valid, ov_m, "out_valid");
    check(req, out_i, oi_m, "out_i");
    check(req, out_q, oq_m, "out_q");
    check(req, frozen, frz_m, "frozen");
  endtask

  initial begin
    #(8ns * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint lf;
    acc_m[0] = 0; acc_m[1] = 0; frz_m = 0; pend_m = 0; ov_m = 0; oi_m = 0; oq_m = 0;
    lf = 12345;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1", out_valid, 0, "out_valid");
    check("R1", out_i, 0, "out_i");
    check("R1", frozen, 0, "frozen");
    thresh = 32'hFFFF_FFFF;
    shift_k = 5'd8;
    step(1, 1234, -777);
    check("R1", out_i, 1234, "first out_i");
    // R2 R3 steady DC, fast loop
    req = "R2";
    for (int n = 0; n < 300; n++) step(1, 1000, -500);
    // R3 gaps in valid
    req = "R3";
    for (int n = 0; n < 60; n++) step(n % 3 == 0, 1000 + n, -500 - n);
    // R4 out-of-range shifts
    req = "R4";
    shift_k = 5'd2;
    for (int n = 0; n < 40; n++) step(1, (n % 2) ? 3000 : -1000, 200);
    shift_k = 5'd31;
    for (int n = 0; n < 40; n++) step(1, 1500, -800);
    shift_k = 5'd8;
    for (int n = 0; n < 200; n++) step(1, 1000, -500);
    // R7 default threshold, two above samples freeze
    req = "R7";
    thresh = 32'd853;
    shift_k = 5'd15;
    step(1, 1000, -500);
    check("R7", frozen, 0, "after one above");
    step(1, 1000, -500);
    check("R7", frozen, 1, "after two above");
    // R9 held estimate still subtracted
    req = "R9";
    for (int n = 0; n < 30; n++) step(1, 4000 - 100*n, -2000 + 50*n);
    // R5 saturation both ways
    req = "R5";
    step(1, -32768, 32767);
    check("R5", out_i, -32768, "neg sat");
    check("R5", out_q, 32767, "pos sat");
    // R10 one opposite then same side
    req = "R10";
    thresh = 32'hFFFF_FFFF;
    step(1, 100, 100);
    thresh = 32'd853;
    step(1, 100, 100);
    step(1, 100, 100);
    check("R10", frozen, 1, "glitch ignored");
    // R8 release
    req = "R8";
    thresh = 32'hFFFF_FFFF;
    step(1, 0, 0);
    check("R8", frozen, 1, "after one below");
    step(1, 0, 0);
    check("R8", frozen, 0, "after two below");
    // R6 pseudo-random stream with moving threshold
    req = "R6";
    shift_k = 5'd10;
    for (int n = 0; n < 3000; n++) begin
      lf = (lf * 1103515245 + 12345) & 64'h7FFF_FFFF;
      if (n % 150 == 0) thresh = 32'(((lf >> 4) & 32'h3F_FFFF));
      step(lf[3:0] != 4'd0, ((lf >> 8) & 16'h3FFF) - 8192 + 6000,
           ((lf >> 3) & 16'h1FFF) - 4096 - 3000);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule